// File: doc/BRIEF.md
# Dual-Rail Delay-Insensitive Register Stage

This block is one register stage of a dual-rail, delay-insensitive pipeline that carries a word of `WIDTH` bits. Each bit travels on a pair of wires, and the pair encodes a logic 0, a logic 1 or an empty "NULL" spacer. The stage moves wavefronts from its input side to its output side. A wavefront is either a whole word of data or a whole word of NULL. The stage also tells the upstream neighbour, through a request line, which kind of wavefront it is ready to accept next.

Each output rail is held by a two-input hysteresis element. The element's inputs are the incoming rail and the request coming back from the downstream stage, so a rail changes only when the downstream stage allows it. All output bits are merged into one full-word completion element. That element drives the request to the previous stage. Because of this, data words and NULL words always alternate, and a data word can never overwrite the one before it.

For a synchronous fabric, every hysteresis element is realised as a flip-flop that is evaluated once per clock. One clock therefore models one gate delay. Synchronous reset places every rail at NULL and raises the upstream request.

Top module: `ncl_dr_stage`

## Requirements
- R1: Bit encoding is rail0=1/rail1=0 for logic 0, rail0=0/rail1=1 for logic 1, and both low for NULL. A data word passes to the output with every bit value unchanged.
- R2: No output bit ever shows both rails high while the inputs are legal.
- R3: While `rst` is high, every output rail is low and `req_to_prev` is high.
- R4: An output rail goes high only when its input rail and `req_from_next` are both high. It goes low only when both are low. In every other case it holds.
- R5: `req_to_prev` falls one clock after every output bit is data. It rises one clock after every output bit is NULL.
- R6: While the output word is part data and part NULL, `req_to_prev` keeps its value.
- R7: An input rail change that the request permits reaches the output one clock later, and `req_to_prev` reacts one clock after that.
- R8: Under a source and a sink that obey the handshake with arbitrary delays, data words arrive in order, and an all-NULL output separates every two data words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Evaluation clock, one gate step per cycle |
| rst | input | 1 | Synchronous active-high reset to NULL |
| in_r0 | input | WIDTH | Incoming rail0 of each bit |
| in_r1 | input | WIDTH | Incoming rail1 of each bit |
| req_from_next | input | 1 | Downstream request: high asks for data, low asks for NULL |
| out_r0 | output | WIDTH | Stored rail0 of each bit |
| out_r1 | output | WIDTH | Stored rail1 of each bit |
| req_to_prev | output | 1 | Full-word completion request to the upstream stage |

## Verification
Directed patterns drive the stage in several distinct ways:
- A full data word while the downstream request is high separates correct capture from wrong latency.
- The same word while the request is low shows whether the rails ignore the request.
- A NULL input while the request is still high checks that stored data is held.
- Half-filled and half-cleared words tell a true full-word completion apart from an OR or AND of the bits.

A randomised source and sink then exchange a long series of random words with random handshake delays. This run exposes reordering, lost words, illegal rail pairs and a missing NULL spacer.

// File: rtl/ncl_pkg.sv
package ncl_pkg;
  // Rail pair packed as {rail1, rail0}
  typedef enum logic [1:0] {
    PAIR_NULL  = 2'b00,
    PAIR_ZERO  = 2'b01,
    PAIR_ONE   = 2'b10,
    PAIR_ILLEG = 2'b11
  } rail_pair_e;

  function automatic logic pair_is_data(input logic r0, input logic r1);
    return r0 | r1;
  endfunction
endpackage

// File: rtl/ncl_celem.sv
module ncl_celem #(
  parameter int N       = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] in,
  output logic         q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (&in)   q <= 1'b1;
    else if (~|in)  q <= 1'b0;
  end

  // Hysteresis: all-high sets, all-low clears, otherwise hold (R4 / R6)
  assert_set_R4: assert property (@(posedge clk) disable iff (rst) (&in) |=> q);
  assert_clear_R4: assert property (@(posedge clk) disable iff (rst) (~|in) |=> !q);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!(&in) && (|in)) |=> $stable(q));
endmodule

// File: rtl/ncl_bit_slice.sv
module ncl_bit_slice (
  input  logic clk,
  input  logic rst,
  input  logic d_r0,
  input  logic d_r1,
  input  logic req,
  output logic q_r0,
  output logic q_r1
);
  ncl_celem #(.N(2), .RST_VAL(1'b0)) u_rail0 (
    .clk(clk), .rst(rst), .in({d_r0, req}), .q(q_r0)
  );
  ncl_celem #(.N(2), .RST_VAL(1'b0)) u_rail1 (
    .clk(clk), .rst(rst), .in({d_r1, req}), .q(q_r1)
  );
endmodule

// File: rtl/ncl_completion.sv
module ncl_completion #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] q_r0,
  input  logic [WIDTH-1:0] q_r1,
  output logic             req_to_prev
);
  import ncl_pkg::*;

  logic [WIDTH-1:0] bit_null;

  always_comb begin
    for (int i = 0; i < WIDTH; i++) bit_null[i] = !pair_is_data(q_r0[i], q_r1[i]);
  end

  // Word-wide C-element on NULL indications: high = request data
  ncl_celem #(.N(WIDTH), .RST_VAL(1'b1)) u_word (
    .clk(clk), .rst(rst), .in(bit_null), .q(req_to_prev)
  );

  assert_fall_on_full_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(req_to_prev) |-> $past(&(q_r0 | q_r1)));
  assert_rise_on_empty_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(req_to_prev) |-> $past(~|(q_r0 | q_r1)));
  assert_mixed_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((|(q_r0 | q_r1)) && !(&(q_r0 | q_r1))) |=> $stable(req_to_prev));
endmodule

// File: rtl/ncl_dr_stage.sv
module ncl_dr_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] in_r0,
  input  logic [WIDTH-1:0] in_r1,
  input  logic             req_from_next,
  output logic [WIDTH-1:0] out_r0,
  output logic [WIDTH-1:0] out_r1,
  output logic             req_to_prev
);
  generate
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
      ncl_bit_slice u_slice (
        .clk (clk),
        .rst (rst),
        .d_r0(in_r0[g]),
        .d_r1(in_r1[g]),
        .req (req_from_next),
        .q_r0(out_r0[g]),
        .q_r1(out_r1[g])
      );
    end
  endgenerate

  ncl_completion #(.WIDTH(WIDTH)) u_done (
    .clk(clk), .rst(rst), .q_r0(out_r0), .q_r1(out_r1), .req_to_prev(req_to_prev)
  );

  assert_no_illegal_R2: assert property (@(posedge clk) disable iff (rst)
    ~|(out_r0 & out_r1));
  assert_set_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
    (|((out_r0 | out_r1) & ~$past(out_r0 | out_r1))) |-> $past(req_from_next));
  assert_clear_needs_low_req_R4: assert property (@(posedge clk) disable iff (rst)
    (|(~(out_r0 | out_r1) & $past(out_r0 | out_r1))) |-> !$past(req_from_next));
  assert_reset_null_R3: assert property (@(posedge clk)
    $past(rst) |-> (~|(out_r0 | out_r1)) && req_to_prev);
endmodule

// File: tb/ncl_dr_stage_test.sv
module ncl_dr_stage_test;
  localparam int W      = 8;
  localparam int NWORDS = 200;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_r0 = '0;
  logic [W-1:0] in_r1 = '0;
  logic         ki = 1'b0;
  logic [W-1:0] out_r0, out_r1;
  logic         ko;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ncl_dr_stage #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .in_r0(in_r0), .in_r1(in_r1),
    .req_from_next(ki), .out_r0(out_r0), .out_r1(out_r1), .req_to_prev(ko)
  );

  function automatic logic [2*W-1:0] enc(input logic [W-1:0] v);
    return {v, ~v};  // {rail1, rail0}
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] r1, input logic [W-1:0] r0);
    in_r1 = r1;
    in_r0 = r0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [W-1:0] words [NWORDS];
    logic [W-1:0] done;
    int tx, rx, src_wait, snk_wait, cyc;
    bit src_data, prev_full, seen_null;

    void'($urandom(32'd4242));
    @(negedge clk);
    @(negedge clk);
    check(out_r0 == '0 && out_r1 == '0, "R3 reset rails", {out_r1, out_r0}, 0);
    check(ko == 1'b1, "R3 reset request", ko, 1);
    rst = 1'b0;

    // R4: data with request low is ignored
    drive(8'hA5, ~8'hA5); ki = 1'b0;
    repeat (2) @(negedge clk);
    check(out_r0 == '0 && out_r1 == '0, "R4 blocked by low request", {out_r1, out_r0}, 0);
    check(ko == 1'b1, "R4 request held", ko, 1);

    // R1/R7: capture with request high, one-cycle latency
    ki = 1'b1;
    @(negedge clk);
    check({out_r1, out_r0} == enc(8'hA5), "R1 R7 word captured", {out_r1, out_r0}, enc(8'hA5));
    check(ko == 1'b1, "R7 request not yet updated", ko, 1);
    @(negedge clk);
    check(ko == 1'b0, "R5 request falls on full word", ko, 0);

    // R4: NULL input with request high holds data
    drive('0, '0);
    repeat (2) @(negedge clk);
    check({out_r1, out_r0} == enc(8'hA5), "R4 data held", {out_r1, out_r0}, enc(8'hA5));
    ki = 1'b0;
    @(negedge clk);
    check(out_r0 == '0 && out_r1 == '0, "R4 cleared", {out_r1, out_r0}, 0);
    @(negedge clk);
    check(ko == 1'b1, "R5 request rises on empty word", ko, 1);

    // R6: partial data word keeps request high
    ki = 1'b1;
    drive(8'h03, 8'h0C);  // low nibble data, high nibble NULL
    repeat (3) @(negedge clk);
    check(ko == 1'b1, "R6 partial fill keeps request", ko, 1);
    drive(8'h33, 8'hCC);
    repeat (2) @(negedge clk);
    check(ko == 1'b0, "R5 completes after fill", ko, 0);
    check({out_r1, out_r0} == enc(8'h33), "R1 full word value", {out_r1, out_r0}, enc(8'h33));
    ki = 1'b0;
    drive(8'h30, 8'hC0);  // low nibble NULL, high nibble still data
    repeat (3) @(negedge clk);
    check(ko == 1'b0, "R6 partial clear keeps request", ko, 0);
    check({out_r1, out_r0} == {8'h30, 8'hC0}, "R4 partial clear", {out_r1, out_r0}, {8'h30, 8'hC0});
    drive('0, '0);
    repeat (2) @(negedge clk);
    check(ko == 1'b1, "R5 request back after clear", ko, 1);

    // R8: random source/sink handshake
    for (int i = 0; i < NWORDS; i++) words[i] = W'($urandom);
    tx = 0; rx = 0; src_wait = 0; snk_wait = 0; cyc = 0;
    src_data = 0; prev_full = 0; seen_null = 1; ki = 1'b1;
    while (rx < NWORDS && cyc < 100000) begin
      @(negedge clk);
      cyc++;
      done = out_r0 | out_r1;
      if ((out_r0 & out_r1) != '0)
        check(0, "R2 illegal pair", {out_r1, out_r0}, 0);
      if (&done && !prev_full) begin
        check(seen_null, "R8 NULL separates words", seen_null, 1);
        check({out_r1, out_r0} == enc(words[rx]), "R8 R1 in-order word",
              {out_r1, out_r0}, enc(words[rx]));
        rx++;
        seen_null = 0;
      end
      if (~|done) seen_null = 1;
      prev_full = &done;
      // source
      if (!src_data && ko && tx < NWORDS) begin
        if (src_wait > 0) src_wait--;
        else begin
          drive(words[tx], ~words[tx]); tx++; src_data = 1;
          src_wait = $urandom_range(0, 3);
        end
      end else if (src_data && !ko) begin
        if (src_wait > 0) src_wait--;
        else begin
          drive('0, '0); src_data = 0;
          src_wait = $urandom_range(0, 3);
        end
      end
      // sink
      if ((ki && &done) || (!ki && ~|done)) begin
        if (snk_wait > 0) snk_wait--;
        else begin
          ki = ~ki;
          snk_wait = $urandom_range(0, 4);
        end
      end
    end
    check(rx == NWORDS, "R8 all words delivered", rx, NWORDS);
    finish_run();
  end
endmodule